// File: doc/BRIEF.md
# Panel Power Sequencer

This block orders panel supply power and panel interface signals whenever a display controller goes into or comes out of a power-save state. A suspend request comes from either of two places: an active-low suspend pin, which is asynchronous to the block clock, or a software suspend bit held in a small configuration register. When a request appears, the block switches the panel supply off first. It keeps the panel signals running until a settle interval has passed, so that the supply can discharge, and then stops them. When the request goes away, the signals start first. The supply returns only after the same interval has passed.

The interval is counted in ticks. A tick lasts `TICK_DIV` clock cycles, and a wait lasts `SETTLE_TICKS` ticks. Real builds set these values to about half a second, and tests set them much shorter. Software reaches two byte-wide registers through a plain write strobe and a combinational read port. One register holds display-mode settings. The other holds the power-save settings. Software updates single fields with read-modify-write, so both registers read back exactly what was written, except for their unused bits. Two status pins, for a busy sequence and a fully suspended panel, let the rest of the chip follow the sequence.

Top module: `lcdpwr_seq`

## Requirements
- R1: After reset, panel power and panel signals are both on, busy and suspended are low, and both registers read 0x00.
- R2: When a suspend request appears while the panel is fully on, panel power drops first. The signals stay on with busy high for exactly SETTLE_TICKS*TICK_DIV cycles. After that the signals stop and suspended goes high.
- R3: When the request is gone while suspended, the signals start with busy high and power stays off for exactly the same SETTLE_TICKS*TICK_DIV cycles. After that power returns.
- R4: The suspend pin is active low. It passes through a two-stage synchronizer, so the state changes on the third rising edge after the pin changes.
- R5: Bit 0 of the power-save register (address 0x1) is the software suspend request. The state changes on the rising edge after the edge that wrote the bit.
- R6: Panel power is never on while the panel signals are off.
- R7: If the request is withdrawn during the power-down wait, the wait still runs to its end. The block then spends one cycle suspended and runs the full power-up wait.
- R8: The power-save register (address 0x1) holds the software suspend bit in bit 0, the refresh select in bits 2:1 and the power disable in bit 3. It reads back bits 3:0 as written, and bits 7:4 read as zero.
- R9: The display-mode register (address 0x0) holds LCD enable in bit 0, CRT enable in bit 1, bits per pixel in bits 4:2 and the simultaneous option in bits 6:5. It reads back bits 6:0 as written, and bit 7 reads as zero.
- R10: Busy is high exactly during the two wait phases.
- R11: Power-disable bit 3 of the power-save register turns panel power off while the panel is on, in the same cycle as the write. It does not stop the signals or start a sequence.
- R12: Any other register address reads as zero. A write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend_n | input | 1 | Asynchronous active-low hardware suspend request |
| reg_we | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Register address (0x0 display mode, 0x1 power save) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| panel_pwr_en | output | 1 | Panel supply enable |
| panel_sig_en | output | 1 | Panel interface signal enable |
| seq_busy | output | 1 | A settle wait is in progress |
| suspended | output | 1 | Panel fully powered down |

## Verification
A write takes effect at its own rising edge: readback and the power-disable bit are visible right after that edge, and a software suspend changes the state one edge later. A pin change moves the state on the third edge, because of the two synchronizer stages. Each wait phase then lasts exactly SETTLE_TICKS*TICK_DIV cycles. The bench drives inputs and samples outputs on falling edges, and it counts these edges from every stimulus. It therefore checks the last cycle of each wait and the first cycle after it, so a wait that is one cycle too short or too long is caught.

// File: rtl/lcdpwr_pkg.sv
package lcdpwr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_DMODE = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_PSAVE = 4'h1;

  localparam int unsigned DMODE_BITS = 7;
  localparam int unsigned PSAVE_BITS = 4;

  localparam int unsigned PS_SWSUSP = 0;
  localparam int unsigned PS_PWRDIS = 3;

  typedef enum logic [1:0] {
    ST_ON           = 2'd0,
    ST_PWR_OFF_WAIT = 2'd1,
    ST_SUSPENDED    = 2'd2,
    ST_SIG_ON_WAIT  = 2'd3
  } lps_state_e;
endpackage

// File: rtl/lcdpwr_sync.sv
module lcdpwr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {STAGES{RST_VAL}};
    else        shreg <= {shreg[STAGES-2:0], din};
  end

  assign dout = shreg[STAGES-1];

  a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shreg[0]) == shreg[1]);
endmodule

// File: rtl/lcdpwr_regs.sv
module lcdpwr_regs
  import lcdpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DMODE_BITS-1:0] dmode,
  output logic [PSAVE_BITS-1:0] psave
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmode <= '0;
      psave <= '0;
    end else if (we) begin
      if (addr == ADDR_DMODE) dmode <= wdata[DMODE_BITS-1:0];
      if (addr == ADDR_PSAVE) psave <= wdata[PSAVE_BITS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_DMODE: rdata[DMODE_BITS-1:0] = dmode;
      ADDR_PSAVE: rdata[PSAVE_BITS-1:0] = psave;
      default:    rdata = '0;
    endcase
  end

  a_r8_psave_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_PSAVE) |-> (rdata[DATA_W-1:PSAVE_BITS] == '0));
  a_r9_dmode_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_DMODE) |-> (rdata[DATA_W-1] == 1'b0));
  a_r12_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != ADDR_DMODE && addr != ADDR_PSAVE) |=> ($stable(dmode) && $stable(psave)));
endmodule

// File: rtl/lcdpwr_timer.sv
module lcdpwr_timer #(
  parameter int unsigned SETTLE_TICKS = 500,
  parameter int unsigned TICK_DIV     = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int unsigned DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned TICK_W = $clog2(SETTLE_TICKS + 1);

  logic [DIV_W-1:0]  pre;
  logic [TICK_W-1:0] ticks;
  logic              tick_end;

  assign tick_end = (pre == '0);
  assign done     = run && tick_end && (ticks == TICK_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      ticks <= '0;
    end else if (load) begin
      pre   <= DIV_W'(TICK_DIV - 1);
      ticks <= TICK_W'(SETTLE_TICKS);
    end else if (run) begin
      if (tick_end) begin
        pre <= DIV_W'(TICK_DIV - 1);
        if (ticks != '0) ticks <= ticks - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  a_r10_run_has_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ticks != '0));
endmodule

// File: rtl/lcdpwr_fsm.sv
module lcdpwr_fsm
  import lcdpwr_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 500,
  parameter int unsigned TICK_DIV     = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       done,
  output lps_state_e state,
  output logic       start,
  output logic       busy
);
  lps_state_e nxt;

  always_comb begin
    nxt   = state;
    start = 1'b0;
    unique case (state)
      ST_ON: if (req) begin
        nxt   = ST_PWR_OFF_WAIT;
        start = 1'b1;
      end
      ST_PWR_OFF_WAIT: if (done) nxt = ST_SUSPENDED;
      ST_SUSPENDED: if (!req) begin
        nxt   = ST_SIG_ON_WAIT;
        start = 1'b1;
      end
      ST_SIG_ON_WAIT: if (done) nxt = ST_ON;
      default: nxt = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ON;
    else        state <= nxt;
  end

  assign busy = (state == ST_PWR_OFF_WAIT) || (state == ST_SIG_ON_WAIT);

  // Independent window counter for the interval checks
  localparam logic [31:0] WAIT_LEN = 32'(SETTLE_TICKS) * 32'(TICK_DIV);
  logic [31:0] wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt <= '0;
    else if (start)  wcnt <= '0;
    else if (busy)   wcnt <= wcnt + 1'b1;
  end

  a_r2_interval_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |-> (wcnt == WAIT_LEN - 1));
  a_r2_enter_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSPENDED) |-> ($past(state) == ST_PWR_OFF_WAIT || $past(state) == ST_SUSPENDED));
  a_r3_exit_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ON && $past(state) != ST_ON) |-> ($past(state) == ST_SIG_ON_WAIT));
  a_r7_wait_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PWR_OFF_WAIT && !done) |=> (state == ST_PWR_OFF_WAIT));
endmodule

// File: rtl/lcdpwr_seq.sv
module lcdpwr_seq
  import lcdpwr_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 500,
  parameter int unsigned TICK_DIV     = 50000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        suspend_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        panel_pwr_en,
  output logic        panel_sig_en,
  output logic        seq_busy,
  output logic        suspended
);
  logic                  pin_q;
  logic [DMODE_BITS-1:0] dmode;
  logic [PSAVE_BITS-1:0] psave;
  logic                  req, done, start, busy;
  lps_state_e            state;

  lcdpwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(suspend_n), .dout(pin_q));

  lcdpwr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .dmode(dmode), .psave(psave));

  assign req = psave[PS_SWSUSP] | ~pin_q;

  lcdpwr_fsm #(.SETTLE_TICKS(SETTLE_TICKS), .TICK_DIV(TICK_DIV)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .state(state), .start(start), .busy(busy));

  lcdpwr_timer #(.SETTLE_TICKS(SETTLE_TICKS), .TICK_DIV(TICK_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .run(busy), .done(done));

  assign panel_pwr_en = (state == ST_ON) && !psave[PS_PWRDIS];
  assign panel_sig_en = (state != ST_SUSPENDED);
  assign seq_busy     = busy;
  assign suspended    = (state == ST_SUSPENDED);

  a_r6_pwr_needs_sig: assert property (@(posedge clk) disable iff (!rst_n)
    panel_pwr_en |-> panel_sig_en);
  a_r10_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_busy && suspended));
  a_r11_pwrdis_off: assert property (@(posedge clk) disable iff (!rst_n)
    psave[PS_PWRDIS] |-> !panel_pwr_en);
endmodule

// File: tb/test_lcdpwr_seq.sv
module test_lcdpwr_seq;
  localparam int unsigned TK = 3;
  localparam int unsigned DV = 4;
  localparam int unsigned W  = TK * DV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       suspend_n;
  logic       reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       panel_pwr_en, panel_sig_en, seq_busy, suspended;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lcdpwr_seq #(.SETTLE_TICKS(TK), .TICK_DIV(DV)) i_lcdpwr_seq (
    .clk(clk), .rst_n(rst_n), .suspend_n(suspend_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .panel_pwr_en(panel_pwr_en), .panel_sig_en(panel_sig_en),
    .seq_busy(seq_busy), .suspended(suspended));

  // {addr, wdata, expected readback}
  localparam logic [19:0] VEC [0:7] = '{
    20'h0_FF_7F, 20'h0_80_00, 20'h0_55_55, 20'h0_2A_2A,
    20'h1_FE_0E, 20'h1_06_06, 20'h1_F0_00, 20'h1_0A_0A
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // packed as {pwr, sig, busy, suspended}
  task automatic chk_out(input string tag, input logic [3:0] exp);
    chk(tag, {4'b0, panel_pwr_en, panel_sig_en, seq_busy, suspended}, {4'b0, exp});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; suspend_n = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk_out("R1 reset outputs", 4'b1100);
    rd("R1 dmode reset", 4'h0, 8'h00);
    rd("R1 psave reset", 4'h1, 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd((VEC[i][19:16] == 4'h0) ? "R9 dmode readback" : "R8 psave readback",
         VEC[i][19:16], VEC[i][7:0]);
    end
    wr(4'h1, 8'h00);

    // R11: power disable bit
    wr(4'h1, 8'h08);
    chk_out("R11 pwrdis off, signals on", 4'b0100);
    step(2);
    chk_out("R11 no sequence started", 4'b0100);
    wr(4'h1, 8'h00);
    chk_out("R11 power back", 4'b1100);

    // R12: stray address
    wr(4'h0, 8'h33);
    wr(4'h7, 8'hFF);
    rd("R12 stray reads zero", 4'h7, 8'h00);
    rd("R12 dmode untouched", 4'h0, 8'h33);
    rd("R12 psave untouched", 4'h1, 8'h00);

    // R5 / R2: software suspend
    wr(4'h1, 8'h01);
    chk_out("R5 still on after write edge", 4'b1100);
    step(1);
    chk_out("R2 power off first, busy", 4'b0110);
    rd("R8 swsusp readback", 4'h1, 8'h01);
    step(W - 1);
    chk_out("R2 last wait cycle", 4'b0110);
    step(1);
    chk_out("R2 signals stopped", 4'b0001);

    // R3: software exit
    wr(4'h1, 8'h00);
    chk_out("R3 still suspended at write edge", 4'b0001);
    step(1);
    chk_out("R3 signals first, R6 power off", 4'b0110);
    step(W - 1);
    chk_out("R3 last wait cycle", 4'b0110);
    step(1);
    chk_out("R3 power back", 4'b1100);

    // R4: hardware pin
    suspend_n = 1'b0;
    step(2);
    chk_out("R4 sync latency", 4'b1100);
    step(1);
    chk_out("R4 entry wait", 4'b0110);
    step(W);
    chk_out("R4 suspended", 4'b0001);
    suspend_n = 1'b1;
    step(2);
    chk_out("R4 release latency", 4'b0001);
    step(1);
    chk_out("R10 exit wait busy", 4'b0110);
    step(W);
    chk_out("R4 back on", 4'b1100);

    // R7: request withdrawn mid-wait
    suspend_n = 1'b0;
    step(3);
    chk_out("R7 entry wait", 4'b0110);
    step(2);
    suspend_n = 1'b1;
    step(W - 3);
    chk_out("R7 wait not shortened", 4'b0110);
    step(1);
    chk_out("R7 one suspended cycle", 4'b0001);
    step(1);
    chk_out("R7 power-up wait", 4'b0110);
    step(W - 1);
    chk_out("R7 full power-up wait", 4'b0110);
    step(1);
    chk_out("R7 power back", 4'b1100);

    summary();
  end
endmodule